// File: doc/BRIEF.md
# Seven-to-One Pixel Word Serializer

This block turns one 28-bit pixel word per pixel clock period into four serial data lanes. Each lane carries seven bits per period. A fifth lane carries a fixed framing pattern that a receiver uses to find frame boundaries. The word holds 24 colour bits (red in bits 7:0, green in bits 15:8, blue in bits 23:16) and four control bits: line sync in bit 24, frame sync in bit 25, data enable in bit 26 and a spare in bit 27.

All logic runs on a bit clock at seven times the pixel rate, which is supplied from outside. The pixel clock is an ordinary input that is sampled on the bit clock. A static select input chooses which pixel clock edge captures the word. The serial output timing is the same in both modes, so a receiver that expects falling-edge capture works with either setting and needs no translation.

A slot counter runs from 0 to 6 on the bit clock. When the count is 0, the shift registers reload from the capture register. The phase-locked loop, the differential drivers and spread-spectrum tracking are not part of this block.

Top module: `lvds7_serializer`

## Requirements
- R1: The word is captured once per pixel period, on the bit clock edge at which the selected pixel clock edge is first seen. The captured word appears on the lanes in the next frame.
- R2: With `strobe_rise`=0 a falling pixel clock edge (sampled 1 then 0) captures. With `strobe_rise`=1 a rising edge (sampled 0 then 1) captures.
- R3: Lane j (j=0..3) carries word bits 7j to 7j+6. In slot s of a frame it shows bit 7j+s, least significant bit first.
- R4: A frame is seven bit-clock cycles long, one slot per cycle. Slot 0 appears in the cycle after the bit clock edge at which the slot count is 0.
- R5: The slot counter counts 0,1,...,6,0 on every bit clock and starts at 0 after reset.
- R6: The framing lane shows 1,1,0,0,0,1,1 in slots 0 to 6 of every frame.
- R7: For the same words and capture slot, both edge settings give identical serial streams.
- R8: During reset all five lanes output 0. The first frame after reset carries an all-zero word on the data lanes.
- R9: Changes on `pix_word` in cycles without a selected edge do not reach the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock at seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on bit_clk |
| strobe_rise | input | 1 | Static capture edge select: 1 rising, 0 falling |
| pix_word | input | 28 | Pixel word: colour bits and control bits |
| lane_out | output | 4 | Serial data lanes |
| frame_clk_out | output | 1 | Framing pattern lane |

## Verification
The assertions assume that `pix_clk` is synchronous to `bit_clk`, spans seven bit clocks per period, and shows at most one selected edge per period. They also assume that this edge never falls in the cycle where the slot count is 0, and that `strobe_rise` stays constant while out of reset. The stimulus aligns each pixel period with the slot counter from reset release and always places the selected edge at slot 3. The idle level of `pix_clk` during reset is chosen so that no selected edge is seen on the first cycle. Outside the capture slot, the stimulus drives the inverse of each word, so that a wrong capture cycle shows up on the lanes.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
  localparam int unsigned LANES_DEF = 4;
  localparam int unsigned SLOTS_DEF = 7;

  // Framing pattern in slot order (bit s = slot s): two high slots at
  // each end of the frame, low in the middle.
  function automatic logic [SLOTS_DEF-1:0] frame_pattern();
    logic [SLOTS_DEF-1:0] p;
    for (int s = 0; s < SLOTS_DEF; s++)
      p[s] = (s < 2) || (s >= SLOTS_DEF - 2);
    return p;
  endfunction

  // Selected-edge detect from current and previous pixel clock samples.
  function automatic logic strobe_seen(logic rise_sel, logic now_v, logic prev_v);
    return rise_sel ? (now_v & ~prev_v) : (~now_v & prev_v);
  endfunction
endpackage

// File: rtl/ser7_slot_counter.sv
module ser7_slot_counter #(
  parameter int unsigned SLOTS = 7,
  localparam int unsigned CW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] slot,
  output logic          frame_start
);
  localparam logic [CW-1:0] LAST = CW'(SLOTS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= '0;
    else if (slot == LAST) slot <= '0;
    else slot <= slot + 1'b1;
  end

  assign frame_start = (slot == '0);

  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST);
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    slot == LAST |=> slot == '0);
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    slot != LAST |=> slot == $past(slot) + 1'b1);
endmodule

// File: rtl/ser7_capture.sv
module ser7_capture
  import ser7_pkg::*;
#(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_sel,
  input  logic              pix_clk,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_q,
  output logic              edge_hit
);
  logic pix_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_prev <= 1'b0;
    else pix_prev <= pix_clk;
  end

  assign edge_hit = strobe_seen(rise_sel, pix_clk, pix_prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else if (edge_hit) word_q <= word_in;
  end

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> word_q == $past(word_in));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_hit |=> $stable(word_q));
  a_r2_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_sel && $rose(pix_clk) |-> edge_hit);
  a_r2_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !rise_sel && $fell(pix_clk) |-> edge_hit);
endmodule

// File: rtl/ser7_lane_shift.sv
module ser7_lane_shift #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SLOTS-1:0] load_val,
  output logic             bit_out
);
  logic [SLOTS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else if (load) sh <= load_val;
    else sh <= {1'b0, sh[SLOTS-1:1]};
  end

  assign bit_out = sh[0];

  a_r4_first: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bit_out == $past(load_val[0]));
  a_r4_next: assert property (@(posedge clk) disable iff (!rst_n)
    load ##1 !load |=> bit_out == $past(load_val[1], 2));
endmodule

// File: rtl/lvds7_serializer.sv
module lvds7_serializer
  import ser7_pkg::*;
#(
  parameter int unsigned LANES = LANES_DEF,
  parameter int unsigned SLOTS = SLOTS_DEF,
  localparam int unsigned WORD_W = LANES * SLOTS,
  localparam int unsigned CW = $clog2(SLOTS)
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              pix_clk,
  input  logic              strobe_rise,
  input  logic [WORD_W-1:0] pix_word,
  output logic [LANES-1:0]  lane_out,
  output logic              frame_clk_out
);
  logic [WORD_W-1:0] held_word;
  logic              cap_hit;
  logic [CW-1:0]     slot;
  logic              frame_start;

  ser7_slot_counter #(.SLOTS(SLOTS)) u_cnt (
    .clk(bit_clk), .rst_n(rst_n), .slot(slot), .frame_start(frame_start)
  );

  ser7_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(bit_clk), .rst_n(rst_n), .rise_sel(strobe_rise),
    .pix_clk(pix_clk), .word_in(pix_word), .word_q(held_word),
    .edge_hit(cap_hit)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ser7_lane_shift #(.SLOTS(SLOTS)) u_sh (
      .clk(bit_clk), .rst_n(rst_n), .load(frame_start),
      .load_val(held_word[g*SLOTS +: SLOTS]), .bit_out(lane_out[g])
    );
  end

  ser7_lane_shift #(.SLOTS(SLOTS)) u_fclk (
    .clk(bit_clk), .rst_n(rst_n), .load(frame_start),
    .load_val(frame_pattern()), .bit_out(frame_clk_out)
  );

  // R6: slot 0 high; slot 2 (shown while count is 3) low
  a_r6_head: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_start |=> frame_clk_out);
  a_r6_mid: assert property (@(posedge bit_clk) disable iff (!rst_n)
    slot == CW'(3) |-> !frame_clk_out);
  // R3: lane 0 slot 0 equals word bit 0 held at load time
  a_r3_lane0: assert property (@(posedge bit_clk) disable iff (!rst_n)
    frame_start |=> lane_out[0] == $past(held_word[0]));
endmodule

// File: tb/lvds7_serializer_tb.sv
module lvds7_serializer_tb;
  localparam int NW = 12;

  logic        bit_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_clk = 1'b0;
  logic        strobe_rise = 1'b0;
  logic [27:0] pix_word = '0;
  logic [3:0]  lane_out;
  logic        frame_clk_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [27:0] exp_q[$];

  always #5 bit_clk = ~bit_clk;

  lvds7_serializer u_dut (
    .bit_clk(bit_clk), .rst_n(rst_n), .pix_clk(pix_clk),
    .strobe_rise(strobe_rise), .pix_word(pix_word),
    .lane_out(lane_out), .frame_clk_out(frame_clk_out)
  );

  function automatic logic [27:0] word_of(int i);
    case (i)
      0: return 28'hFFFFFFF;
      1: return 28'h0000001;
      2: return 28'h8000000;
      3: return 28'hAAAAAAA;
      4: return 28'h5555555;
      5: return 28'h7000000;
      6: return 28'h00000FE;
      default: return 28'(32'h9E3779B9 * (i + 3));
    endcase
  endfunction

  // pixel clock level per slot; selected edge always lands at slot 3
  function automatic logic pclk_level(logic rise, int s);
    return rise ? (s >= 3) : (s < 3);
  endfunction

  task automatic drive_phase(logic rise);
    exp_q.push_back(28'h0);               // R8: first frame is zero
    for (int p = 0; p <= NW; p++) begin
      if (p < NW) exp_q.push_back(word_of(p));
      for (int s = 0; s < 7; s++) begin
        pix_clk  = (p < NW) ? pclk_level(rise, s) : pclk_level(rise, 6);
        pix_word = (p < NW && s == 3) ? word_of(p) : ~word_of(p); // R9 junk
        @(negedge bit_clk);
      end
    end
  endtask

  task automatic monitor_phase(logic rise);
    for (int f = 0; f <= NW; f++) begin
      logic [27:0] got;
      logic [6:0]  fc;
      logic [27:0] exp;
      for (int s = 0; s < 7; s++) begin
        @(negedge bit_clk);
        for (int l = 0; l < 4; l++) got[l*7+s] = lane_out[l];
        fc[s] = frame_clk_out;
      end
      exp = exp_q.pop_front();
      n_chk++;
      if (got !== exp) begin
        n_bad++;
        $display("FAIL R1/R3/R4/R7/R9 mode=%0d frame %0d: got %h expected %h",
                 rise, f, got, exp);
      end
      n_chk++;
      if (fc !== 7'b1100011) begin
        n_bad++;
        $display("FAIL R6/R5 mode=%0d frame %0d: got %b expected %b",
                 rise, f, fc, 7'b1100011);
      end
    end
  endtask

  task automatic run_phase(logic rise);
    rst_n = 1'b0;
    strobe_rise = rise;
    pix_clk = pclk_level(rise, 6);
    pix_word = 28'hFFFFFFF;
    repeat (3) @(negedge bit_clk);
    n_chk++;
    if (lane_out !== 4'b0 || frame_clk_out !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 reset: got %b/%b expected 0000/0", lane_out, frame_clk_out);
    end
    rst_n = 1'b1;
    fork
      drive_phase(rise);
      monitor_phase(rise);
    join
  endtask

  initial begin
    fork
      begin
        run_phase(1'b0);   // R2 falling capture
        run_phase(1'b1);   // R2 rising capture, R7 same stream
      end
      begin
        repeat (5000) @(posedge bit_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule